// File: doc/BRIEF.md
# Serial Flash Vendor Setup Sequencer

This block runs once after a start pulse, before a quad-read engine takes over the flash. Over a plain single-line SPI link (mode 0, clock idle low) it reads the device identification and keeps only the first returned byte, the manufacturer code. It then picks one of three paths from that byte. The path sets the device's volatile dummy-cycle and execute-in-place settings so that they match what the read engine assumes.

For code 20h, the block reads the volatile configuration register. It writes the register back with the dummy-cycle count in bits [7:4] and bit 3 driven from the XIP request, and it keeps bits [2:0]. For code C2h, it reads status register 1 and the configuration register. It then writes both back in one status-write command, with the two dummy-cycle selector bits and the 4-byte-address bit cleared. For code 01h, it sends no command after the identification read. Any other code ends the run with an error. After every register write, the block polls the status register until the write-in-progress bit clears.

The block has no data stream at its edge. The manufacturer byte is a held value qualified by a valid flag, so no back-pressure applies. Start, XIP request, done and error are plain level or pulse pins.

Top module: `flash_vendor_cfg`

## Requirements
- R1: A start pulse in idle clears done, error and the ID valid flag. It then issues one transaction, opcode 9Fh followed by one receive byte (00h sent). The received byte appears on the manufacturer output with the valid flag set, and it stays stable until the next start.
- R2: For manufacturer code 01h, the run ends with done=1 and error=0 after the identification transaction, with no further transaction.
- R3: For code 20h, the transactions are [85h, rx], then [06h], then [81h, V]. V[7:4] holds the DUMMY_CYCLES parameter and V[2:0] equals bits [2:0] of the byte read by 85h.
- R4: In the 20h write, V[3] is 0 when the XIP request was high at start, and 1 when it was low.
- R5: For code C2h, the transactions are [05h, rx], [15h, rx], [06h], then [01h, S, C]. S is the byte read by 05h and C is the byte read by 15h ANDed with 1Fh, so bits [7:5] are cleared.
- R6: Every register-write transaction (81h or 01h) comes directly after a single-byte 06h transaction.
- R7: After a register write, the block repeats [05h, rx] while received bit 0 is 1. It ends with done=1 and error=0 on the first read with bit 0 equal to 0.
- R8: If MAX_POLLS status reads in a row all show bit 0 set, the run ends with done=1 and error=1, and no further transaction follows.
- R9: Any code other than 01h, 20h or C2h ends the run with done=1 and error=1 after the identification transaction.
- R10: SPI mode 0: chip select high forces the serial clock low. MOSI is stable while the clock is high, and bytes are sent most significant bit first.
- R11: Error is only ever high together with done. Chip select is high whenever done is high. A start pulse during a run has no effect on the transactions.
- R12: After reset, chip select is high, the serial clock is low, and done, error and the ID valid flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a run when idle |
| xip_req_i | input | 1 | XIP request, sampled at start |
| spi_sclk_o | output | 1 | Serial clock to the flash |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| mfr_id_o | output | 8 | Latched manufacturer byte |
| mfr_id_valid_o | output | 1 | Manufacturer byte is valid |
| done_o | output | 1 | Run finished (held until next start) |
| error_o | output | 1 | Run finished abnormally (unknown code or poll limit) |

## Verification
The checker watches the serial-line rules on every cycle: the clock is held low while deselected and MOSI is steady during a high clock phase. It also checks the status pins: error implies done, done implies deselected, and the manufacturer byte holds while valid. The command order per vendor code cannot be shown by per-cycle properties. The same holds for the read-modify-write byte values, the XIP bit polarity, the poll count and the poll limit. The bench shows these by recording every transaction in a flash model and comparing against a sequence computed from the requirements, across vendor codes, register contents, XIP settings and busy lengths.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;
  localparam logic [7:0] OP_READ_ID   = 8'h9F;
  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_RD_STAT   = 8'h05;
  localparam logic [7:0] OP_RD_CONF   = 8'h15;
  localparam logic [7:0] OP_WR_STAT   = 8'h01;
  localparam logic [7:0] OP_RD_VOLCFG = 8'h85;
  localparam logic [7:0] OP_WR_VOLCFG = 8'h81;

  localparam logic [7:0] MFR_UNTOUCHED = 8'h01;
  localparam logic [7:0] MFR_VOLCFG    = 8'h20;
  localparam logic [7:0] MFR_STATPAIR  = 8'h C2;

  localparam logic [7:0] CONF_KEEP_MASK = 8'h1F;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_ID, ST_RD_VOLCFG, ST_RD_STAT1, ST_RD_CONF,
    ST_WR_EN, ST_WR_VOLCFG, ST_WR_STATPAIR, ST_POLL
  } step_e;

  typedef enum logic [1:0] { PH_IDLE, PH_ISSUE, PH_WAIT, PH_GAP } phase_e;
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_HALF - 1);

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q, rx_q;
  logic          busy_q, sclk_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          sh_q   <= tx_i;
          div_q  <= '0;
          bit_q  <= '0;
          sclk_q <= 1'b0;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = busy_q & sh_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/cmd_table.sv
module cmd_table
  import flash_cfg_pkg::*;
#(
  parameter int DUMMY_CYCLES = 9
) (
  input  step_e      step_i,
  input  logic [1:0] idx_i,
  input  logic       xip_i,
  input  logic [7:0] volcfg_i,
  input  logic [7:0] stat1_i,
  input  logic [7:0] conf_i,
  output logic [1:0] last_idx_o,
  output logic [7:0] byte_o
);
  logic [7:0] opcode;
  logic [7:0] pay0, pay1;

  always_comb begin
    opcode     = 8'h00;
    pay0       = 8'h00;
    pay1       = 8'h00;
    last_idx_o = 2'd1;
    unique case (step_i)
      ST_RD_ID:       opcode = OP_READ_ID;
      ST_RD_VOLCFG:   opcode = OP_RD_VOLCFG;
      ST_RD_STAT1,
      ST_POLL:        opcode = OP_RD_STAT;
      ST_RD_CONF:     opcode = OP_RD_CONF;
      ST_WR_EN: begin
        opcode     = OP_WR_ENABLE;
        last_idx_o = 2'd0;
      end
      ST_WR_VOLCFG: begin
        opcode = OP_WR_VOLCFG;
        pay0   = {4'(DUMMY_CYCLES), ~xip_i, volcfg_i[2:0]};
      end
      ST_WR_STATPAIR: begin
        opcode     = OP_WR_STAT;
        pay0       = stat1_i;
        pay1       = conf_i & CONF_KEEP_MASK;
        last_idx_o = 2'd2;
      end
      default: ;
    endcase
    unique case (idx_i)
      2'd0:    byte_o = opcode;
      2'd1:    byte_o = pay0;
      2'd2:    byte_o = pay1;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
  import flash_cfg_pkg::*;
#(
  parameter int MAX_POLLS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       xip_req_i,
  input  logic [1:0] last_idx_i,
  input  logic       eng_done_i,
  input  logic [7:0] eng_rx_i,
  output logic       eng_go_o,
  output logic       cs_n_o,
  output step_e      step_o,
  output logic [1:0] idx_o,
  output logic       xip_o,
  output logic [7:0] volcfg_o,
  output logic [7:0] stat1_o,
  output logic [7:0] conf_o,
  output logic [7:0] id_o,
  output logic       id_valid_o,
  output logic       done_o,
  output logic       error_o
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  phase_e        ph_q;
  step_e         step_q;
  logic [1:0]    idx_q;
  logic [PW-1:0] poll_q;
  logic          go_q, cs_n_q, done_q, err_q, xip_q, idv_q;
  logic [7:0]    id_q, vcfg_q, st1_q, conf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      step_q <= ST_IDLE;
      idx_q  <= '0;
      poll_q <= '0;
      go_q   <= 1'b0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      xip_q  <= 1'b0;
      idv_q  <= 1'b0;
      id_q   <= '0;
      vcfg_q <= '0;
      st1_q  <= '0;
      conf_q <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
          idv_q  <= 1'b0;
          xip_q  <= xip_req_i;
          step_q <= ST_RD_ID;
          idx_q  <= '0;
          ph_q   <= PH_ISSUE;
        end
        PH_ISSUE: begin
          cs_n_q <= 1'b0;
          go_q   <= 1'b1;
          ph_q   <= PH_WAIT;
        end
        PH_WAIT: if (eng_done_i) begin
          if (idx_q == last_idx_i) begin
            cs_n_q <= 1'b1;
            ph_q   <= PH_GAP;
          end else begin
            idx_q <= idx_q + 2'd1;
            ph_q  <= PH_ISSUE;
          end
        end
        PH_GAP: begin
          idx_q <= '0;
          ph_q  <= PH_ISSUE;
          unique case (step_q)
            ST_RD_ID: begin
              id_q  <= eng_rx_i;
              idv_q <= 1'b1;
              if (eng_rx_i == MFR_VOLCFG)        step_q <= ST_RD_VOLCFG;
              else if (eng_rx_i == MFR_STATPAIR) step_q <= ST_RD_STAT1;
              else begin
                ph_q   <= PH_IDLE;
                step_q <= ST_IDLE;
                done_q <= 1'b1;
                err_q  <= (eng_rx_i != MFR_UNTOUCHED);
              end
            end
            ST_RD_VOLCFG: begin
              vcfg_q <= eng_rx_i;
              step_q <= ST_WR_EN;
            end
            ST_RD_STAT1: begin
              st1_q  <= eng_rx_i;
              step_q <= ST_RD_CONF;
            end
            ST_RD_CONF: begin
              conf_q <= eng_rx_i;
              step_q <= ST_WR_EN;
            end
            ST_WR_EN: step_q <= (id_q == MFR_VOLCFG) ? ST_WR_VOLCFG : ST_WR_STATPAIR;
            ST_WR_VOLCFG, ST_WR_STATPAIR: begin
              poll_q <= '0;
              step_q <= ST_POLL;
            end
            ST_POLL: begin
              if (!eng_rx_i[0] || poll_q == POLL_LAST) begin
                ph_q   <= PH_IDLE;
                step_q <= ST_IDLE;
                done_q <= 1'b1;
                err_q  <= eng_rx_i[0];
              end else begin
                poll_q <= poll_q + PW'(1);
              end
            end
            default: begin
              ph_q   <= PH_IDLE;
              step_q <= ST_IDLE;
            end
          endcase
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign eng_go_o   = go_q;
  assign cs_n_o     = cs_n_q;
  assign step_o     = step_q;
  assign idx_o      = idx_q;
  assign xip_o      = xip_q;
  assign volcfg_o   = vcfg_q;
  assign stat1_o    = st1_q;
  assign conf_o     = conf_q;
  assign id_o       = id_q;
  assign id_valid_o = idv_q;
  assign done_o     = done_q;
  assign error_o    = err_q;
endmodule

// File: rtl/flash_vendor_cfg.sv
module flash_vendor_cfg
  import flash_cfg_pkg::*;
#(
  parameter int CLK_HALF     = 2,
  parameter int MAX_POLLS    = 16,
  parameter int DUMMY_CYCLES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       xip_req_i,
  output logic       spi_sclk_o,
  output logic       spi_cs_n_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i,
  output logic [7:0] mfr_id_o,
  output logic       mfr_id_valid_o,
  output logic       done_o,
  output logic       error_o
);
  step_e      step;
  logic [1:0] idx, last_idx;
  logic [7:0] tx_byte, rx_byte, vcfg, st1, conf;
  logic       go, eng_done, xip;

  spi_byte_engine #(.CLK_HALF(CLK_HALF)) u_engine (
    .clk(clk), .rst_n(rst_n), .go_i(go), .tx_i(tx_byte), .miso_i(spi_miso_i),
    .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o), .done_o(eng_done), .rx_o(rx_byte)
  );

  cmd_table #(.DUMMY_CYCLES(DUMMY_CYCLES)) u_table (
    .step_i(step), .idx_i(idx), .xip_i(xip), .volcfg_i(vcfg), .stat1_i(st1),
    .conf_i(conf), .last_idx_o(last_idx), .byte_o(tx_byte)
  );

  cfg_sequencer #(.MAX_POLLS(MAX_POLLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .xip_req_i(xip_req_i),
    .last_idx_i(last_idx), .eng_done_i(eng_done), .eng_rx_i(rx_byte),
    .eng_go_o(go), .cs_n_o(spi_cs_n_o), .step_o(step), .idx_o(idx), .xip_o(xip),
    .volcfg_o(vcfg), .stat1_o(st1), .conf_o(conf), .id_o(mfr_id_o),
    .id_valid_o(mfr_id_valid_o), .done_o(done_o), .error_o(error_o)
  );
endmodule

// File: rtl/flash_vendor_cfg_chk.sv
module flash_vendor_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_sclk_o,
  input logic       spi_cs_n_o,
  input logic       spi_mosi_o,
  input logic [7:0] mfr_id_o,
  input logic       mfr_id_valid_o,
  input logic       done_o,
  input logic       error_o
);
  // R10: deselected line keeps the clock low
  a_r10_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sclk_o);
  // R10: data does not move during a high clock phase
  a_r10_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk_o && $past(spi_sclk_o)) |-> $stable(spi_mosi_o));
  // R11: error only with done
  a_r11_error_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> done_o);
  // R11: finished means deselected
  a_r11_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> spi_cs_n_o);
  // R1: manufacturer byte holds while valid
  a_r1_id_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mfr_id_valid_o && $past(mfr_id_valid_o)) |-> $stable(mfr_id_o));
endmodule

bind flash_vendor_cfg flash_vendor_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk_o(spi_sclk_o), .spi_cs_n_o(spi_cs_n_o),
  .spi_mosi_o(spi_mosi_o), .mfr_id_o(mfr_id_o), .mfr_id_valid_o(mfr_id_valid_o),
  .done_o(done_o), .error_o(error_o)
);

// File: tb/flash_vendor_cfg_test.sv
module flash_vendor_cfg_test;
  localparam int MAXP  = 4;
  localparam int DUMMY = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, xip = 1'b0, miso = 1'b0;
  logic sclk, cs_n, mosi, done, err, idv;
  logic [7:0] id;

  always #2 clk = ~clk;

  flash_vendor_cfg #(.CLK_HALF(2), .MAX_POLLS(MAXP), .DUMMY_CYCLES(DUMMY)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .xip_req_i(xip),
    .spi_sclk_o(sclk), .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .mfr_id_o(id), .mfr_id_valid_o(idv), .done_o(done), .error_o(err)
  );

  int n_chk = 0, n_bad = 0;

  // flash model configuration
  logic [7:0] m_id, m_vcfg, m_sr, m_cr;
  int m_wip_cfg, m_wip_left;

  // capture of each transaction
  logic [7:0] cur, resp;
  int g, trlen;
  logic [7:0] trbuf [0:3];
  logic [7:0] log_b [0:63][0:3];
  int log_n [0:63];
  int nlog;

  function automatic logic [7:0] respond(input logic [7:0] op);
    case (op)
      8'h9F:   return m_id;
      8'h85:   return m_vcfg;
      8'h15:   return m_cr;
      8'h05:   return (m_wip_left > 0) ? (m_sr | 8'h01) : m_sr;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge cs_n) begin
    g = 0; trlen = 0; miso = 1'b0;
  end
  always @(posedge sclk) if (!cs_n) begin
    cur = {cur[6:0], mosi};
    g++;
    if (g % 8 == 0) begin
      if (trlen < 4) trbuf[trlen] = cur;
      trlen++;
      if (g == 8) resp = respond(cur);
    end
  end
  always @(negedge sclk) if (!cs_n && g >= 8) miso = resp[7 - (g % 8)];
  always @(posedge cs_n) if (rst_n) begin
    if (nlog < 64) begin
      for (int k = 0; k < 4; k++) log_b[nlog][k] = (k < trlen) ? trbuf[k] : 8'h00;
      log_n[nlog] = trlen;
    end
    nlog++;
    if (trbuf[0] == 8'h81 || trbuf[0] == 8'h01) m_wip_left = m_wip_cfg;
    else if (trbuf[0] == 8'h05 && m_wip_left > 0) m_wip_left--;
  end

  // expected transcript
  logic [7:0] e_b [0:63][0:3];
  int e_n [0:63];
  string e_tag [0:63];
  int ne;

  task automatic add(input int len, input logic [7:0] b0, b1, b2, input string tag);
    e_b[ne][0] = b0; e_b[ne][1] = b1; e_b[ne][2] = b2; e_b[ne][3] = 8'h00;
    e_n[ne] = len; e_tag[ne] = tag; ne++;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] vid, input logic x, input logic [7:0] vc,
                     input logic [7:0] sr, input logic [7:0] cr, input int wip);
    int cyc, np;
    bit exp_err;
    m_id = vid; m_vcfg = vc; m_sr = sr; m_cr = cr; m_wip_cfg = wip; m_wip_left = 0;
    nlog = 0; ne = 0; exp_err = 1'b0;
    add(2, 8'h9F, 8'h00, 8'h00, "R1");
    np = (wip < MAXP) ? wip + 1 : MAXP;
    if (vid == 8'h20) begin
      add(2, 8'h85, 8'h00, 8'h00, "R3");
      add(1, 8'h06, 8'h00, 8'h00, "R6");
      add(2, 8'h81, {4'(DUMMY), ~x, vc[2:0]}, 8'h00, "R3_R4");
    end else if (vid == 8'hC2) begin
      add(2, 8'h05, 8'h00, 8'h00, "R5");
      add(2, 8'h15, 8'h00, 8'h00, "R5");
      add(1, 8'h06, 8'h00, 8'h00, "R6");
      add(3, 8'h01, sr, cr & 8'h1F, "R5");
    end else begin
      exp_err = (vid != 8'h01);
      np = 0;
    end
    for (int p = 0; p < np; p++) add(2, 8'h05, 8'h00, 8'h00, (wip >= MAXP) ? "R8" : "R7");
    if (np > 0 && wip >= MAXP) exp_err = 1'b1;

    @(negedge clk); xip = x; start = 1'b1;
    @(negedge clk); start = 1'b0; xip = ~x;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (cyc == 20) start = 1'b1;   // R11: ignored mid-run
      else start = 1'b0;
    end
    start = 1'b0;
    check("R11 watchdog", (cyc < 20000), 1);
    repeat (4) @(negedge clk);
    check("R1 id", id, vid);
    check("R1 id_valid", idv, 1);
    check("R2_R7 done", done, 1);
    check(exp_err ? "R8_R9 error" : "R2_R7 error", err, exp_err);
    check("R2_R11 transaction count", nlog, ne);
    for (int t = 0; t < ne && t < nlog; t++) begin
      check({e_tag[t], " length"}, log_n[t], e_n[t]);
      for (int k = 0; k < e_n[t]; k++) check({e_tag[t], " byte"}, log_b[t][k], e_b[t][k]);
    end
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL R11 global watchdog actual=expired expected=finished");
    finish_up();
  end

  initial begin
    logic [7:0] vals [0:2];
    logic [7:0] others [0:4];
    int wips [0:2];
    vals = '{8'h00, 8'hFF, 8'h5A};
    others = '{8'h01, 8'h00, 8'hFF, 8'h21, 8'hC3};
    wips = '{0, 2, MAXP};
    nlog = 0;
    repeat (3) @(negedge clk);
    check("R12 cs_n", cs_n, 1);
    check("R12 sclk", sclk, 0);
    check("R12 done", done, 0);
    check("R12 error", err, 0);
    check("R12 id_valid", idv, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 idle cs_n", cs_n, 1);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < 3; w++) begin
          run(8'h20, b[0], vals[a] ^ 8'h03, 8'h40, 8'h00, wips[w]);
          run(8'hC2, b[0], 8'h00, {vals[2-a][7:1], 1'b0}, vals[a] ^ 8'h24, wips[w]);
        end
    for (int o = 0; o < 5; o++)
      for (int b = 0; b < 2; b++) run(others[o], b[0], 8'h00, 8'h00, 8'h00, 0);
    finish_up();
  end
endmodule